// File: doc/BRIEF.md
# Cascadable Segment RAM Write Controller

This block takes a stream of bytes, each flagged as a command or as display data, and stores the display data in a segment memory of 40 addresses by 4 bits. Commands set a write pointer, choose how many bits of each address a byte fills (the drive mode), pick the lower or upper half of each address for the two narrow modes, and load a small device counter. Data bytes are stored one bit per clock cycle at the position the pointer gives. The pointer then moves on after every address it fills.

Several of these blocks can share one byte stream. Each block has its own hardware address on `hw_sub`. It writes only while its device counter equals that address, and it advances exactly as if it had written when the two differ. When the pointer runs past the last address, it wraps to zero and the device counter steps on. The stream therefore flows into the next chained block, even partway through a byte. A combinational read port gives the stored contents to the display logic downstream.

Top module: `disp_ram_writer`

## Requirements
- R1: After reset, `busy` is 0, every address reads 0, the pointer and device counter are 0, the mode is static and the lower half is selected.
- R2: A byte is taken on a rising edge where `in_valid` is 1 and `busy` is 0. A data byte (`in_cmd`=0) holds `busy` high for exactly 8 cycles and stores one bit per cycle, bit 7 first. A command byte (`in_cmd`=1) takes effect on that edge and never raises `busy`.
- R3: A command with bit 7 clear loads the pointer from bits 5:0, and the next data bit goes to the first bit of that address. A value of 40 or more leaves the pointer and the bit position unchanged.
- R4: Command `100xxxMM` sets the mode: 00 static (1 bit per address), 01 two-way (2 bits), 10 three-way (3 bits), 11 four-way (4 bits). It also restarts the bit position at the first bit of the current address.
- R5: Command `101DDDDD` loads the device counter from the low 3 bits. Command `110xxxxB` selects the upper half when B=1 and the lower half when B=0. Command `111xxxxx` changes nothing.
- R6: Within one address, successive data bits fill the lower bit index first: in static mode bit 0; in two-way mode bits 0 then 1; in four-way mode bits 0 to 3. A byte therefore advances the pointer by 8, 4 or 2 addresses.
- R7: With the upper half selected, static mode writes bit 2 instead of bit 0, and two-way mode writes bits 2 then 3 instead of 0 then 1. The other bits of the address keep their values.
- R8: In three-way mode, bits 0, 1 and 2 of each address are filled in order. The bit position is kept from one data byte to the next, so a byte may begin or end partway through an address.
- R9: A data bit is stored only while the device counter equals `hw_sub`. A bit that is not stored leaves the memory unchanged, but the pointer and bit position still advance.
- R10: After the last bit of address 39, the pointer wraps to 0 and the device counter increments modulo 8. This takes effect from the next data bit, even within a byte.
- R11: The half selection has no effect in three-way and four-way modes.
- R12: `rd_data` shows the stored 4 bits of address `rd_addr` combinationally, and 0 for addresses of 40 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_sub | input | 3 | Hardware address of this block in a chain |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_cmd | input | 1 | 1: command byte, 0: display data byte |
| in_byte | input | 8 | Byte value |
| busy | output | 1 | A data byte is being stored; no byte is taken |
| rd_addr | input | 6 | Read address |
| rd_data | output | 4 | Contents of the read address |

## Verification
The bench builds the block with its defaults: 40 addresses and a 3-bit device counter. A pointer load near address 39 followed by one byte therefore reaches the wrap and the carry into the device counter. The bench changes `hw_sub` between bytes, so that a single byte can start in a non-matching device and finish in the matching one, or the reverse. Three-way mode is the only mode in which a byte ends off an address boundary, so the bench chains bytes in that mode and then switches mode to check that the bit position restarts.

// File: rtl/disp_pkg.sv
package disp_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BYTE_W     = 8;
  localparam int CELL_BITS  = 4;
  localparam int CELL_IDX_W = $clog2(CELL_BITS);
  localparam int PTR_FLD_W  = 6;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'b00,
    MODE_DUO    = 2'b01,
    MODE_TRIO   = 2'b10,
    MODE_QUAD   = 2'b11
  } mux_mode_e;

  typedef struct packed {
    logic                 ld_ptr;
    logic [PTR_FLD_W-1:0] ptr_val;
    logic                 set_mode;
    mux_mode_e            mode;
    logic                 set_dev;
    logic [4:0]           dev;
    logic                 set_bank;
    logic                 bank;
  } cmd_t;

  // last bit index used in one address for a mode
  function automatic logic [CELL_IDX_W-1:0] last_pos(mux_mode_e m);
    logic [CELL_IDX_W-1:0] r;
    case (m)
      MODE_STATIC: r = CELL_IDX_W'(0);
      MODE_DUO:    r = CELL_IDX_W'(1);
      MODE_TRIO:   r = CELL_IDX_W'(2);
      default:     r = CELL_IDX_W'(3);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
  import disp_pkg::*;
#(
  parameter int ADDR_COUNT = 40
) (
  input  logic              take_cmd,
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_t              cmd
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [2:0] opc;
  logic       ptr_ok;

  assign opc    = cmd_byte[7:5];
  assign ptr_ok = (int'(cmd_byte[PTR_FLD_W-1:0]) < ADDR_COUNT);

  always_comb begin
    cmd          = '0;
    cmd.ptr_val  = cmd_byte[PTR_FLD_W-1:0];
    cmd.mode     = mux_mode_e'(cmd_byte[1:0]);
    cmd.dev      = cmd_byte[4:0];
    cmd.bank     = cmd_byte[0];
    if (take_cmd) begin
      if (!cmd_byte[7]) begin
        cmd.ld_ptr = ptr_ok;
      end else begin
        case (opc)
          3'b100:  cmd.set_mode = 1'b1;
          3'b101:  cmd.set_dev  = 1'b1;
          3'b110:  cmd.set_bank = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/disp_wr_seq.sv
module disp_wr_seq
  import disp_pkg::*;
#(
  parameter int ADDR_COUNT = 40,
  parameter int SUB_W      = 3,
  localparam int ADDR_W    = $clog2(ADDR_COUNT),
  localparam int CNT_W     = $clog2(BYTE_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SUB_W-1:0]      hw_sub,
  input  logic                  take_data,
  input  logic [BYTE_W-1:0]     data_byte,
  input  cmd_t                  cmd,
  output logic                  busy,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [CELL_IDX_W-1:0] wr_bit,
  output logic                  wr_val,
  output logic [ADDR_W-1:0]     ptr,
  output logic [SUB_W-1:0]      sub,
  output logic [CELL_IDX_W-1:0] pos,
  output mux_mode_e             mode
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ADDR_COUNT - 1);

  logic [ADDR_W-1:0]     ptr_q, ptr_d;
  logic [SUB_W-1:0]      sub_q, sub_d;
  logic [CELL_IDX_W-1:0] pos_q, pos_d;
  mux_mode_e             mode_q, mode_d;
  logic                  bank_q, bank_d;
  logic [BYTE_W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  shifting;
  logic                  state_en;
  logic [CELL_IDX_W-1:0] base_bit;

  assign shifting = (cnt_q != '0);
  assign state_en = shifting | take_data | cmd.ld_ptr | cmd.set_mode
                  | cmd.set_dev | cmd.set_bank;

  // upper half only applies to the two narrow modes
  assign base_bit = (bank_q && (mode_q == MODE_STATIC || mode_q == MODE_DUO))
                  ? CELL_IDX_W'(2) : '0;

  always_comb begin
    ptr_d  = ptr_q;
    sub_d  = sub_q;
    pos_d  = pos_q;
    mode_d = mode_q;
    bank_d = bank_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (shifting) begin
      sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
      cnt_d = cnt_q - CNT_W'(1);
      if (pos_q == last_pos(mode_q)) begin
        pos_d = '0;
        if (ptr_q == LAST_ADDR) begin
          ptr_d = '0;
          sub_d = sub_q + SUB_W'(1);
        end else begin
          ptr_d = ptr_q + ADDR_W'(1);
        end
      end else begin
        pos_d = pos_q + CELL_IDX_W'(1);
      end
    end else if (take_data) begin
      sh_d  = data_byte;
      cnt_d = CNT_W'(BYTE_W);
    end else begin
      if (cmd.ld_ptr) begin
        ptr_d = ADDR_W'(cmd.ptr_val);
        pos_d = '0;
      end
      if (cmd.set_mode) begin
        mode_d = cmd.mode;
        pos_d  = '0;
      end
      if (cmd.set_dev)  sub_d  = cmd.dev[SUB_W-1:0];
      if (cmd.set_bank) bank_d = cmd.bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      sub_q  <= '0;
      pos_q  <= '0;
      mode_q <= MODE_STATIC;
      bank_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (state_en) begin
      ptr_q  <= ptr_d;
      sub_q  <= sub_d;
      pos_q  <= pos_d;
      mode_q <= mode_d;
      bank_q <= bank_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy    = shifting;
  assign wr_en   = shifting && (sub_q == hw_sub);
  assign wr_addr = ptr_q;
  assign wr_bit  = base_bit + pos_q;
  assign wr_val  = sh_q[BYTE_W-1];
  assign ptr     = ptr_q;
  assign sub     = sub_q;
  assign pos     = pos_q;
  assign mode    = mode_q;
endmodule

// File: rtl/disp_seg_ram.sv
module disp_seg_ram
  import disp_pkg::*;
#(
  parameter int ADDR_COUNT = 40,
  localparam int ADDR_W    = $clog2(ADDR_COUNT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CELL_IDX_W-1:0] wr_bit,
  input  logic                  wr_val,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [CELL_BITS-1:0]  rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CELL_BITS-1:0] cells [ADDR_COUNT];

  for (genvar a = 0; a < ADDR_COUNT; a++) begin : g_cell
    logic                 hit;
    logic [CELL_BITS-1:0] cell_q, cell_d;

    assign hit = wr_en && (wr_addr == ADDR_W'(a));

    always_comb begin
      cell_d         = cell_q;
      cell_d[wr_bit] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '0;
      else if (hit) cell_q <= cell_d;
    end

    assign cells[a] = cell_q;
  end

  always_comb begin
    rd_data = '0;
    for (int a = 0; a < ADDR_COUNT; a++) begin
      if (rd_addr == ADDR_W'(a)) rd_data = cells[a];
    end
  end
endmodule

// File: rtl/disp_ram_writer.sv
module disp_ram_writer
  import disp_pkg::*;
#(
  parameter int ADDR_COUNT = 40,
  parameter int SUB_W      = 3,
  localparam int ADDR_W    = $clog2(ADDR_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SUB_W-1:0]     hw_sub,
  input  logic                 in_valid,
  input  logic                 in_cmd,
  input  logic [BYTE_W-1:0]    in_byte,
  output logic                 busy,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CELL_BITS-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  logic                  rst_sync_n;
  logic                  take_data, take_cmd;
  cmd_t                  cmd;
  logic                  wr_en, wr_val;
  logic [ADDR_W-1:0]     wr_addr, ptr;
  logic [CELL_IDX_W-1:0] wr_bit, pos;
  logic [SUB_W-1:0]      sub;
  mux_mode_e             mode;

  assign take_data = in_valid && !busy && !in_cmd;
  assign take_cmd  = in_valid && !busy && in_cmd;

  disp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  disp_cmd_decode #(.ADDR_COUNT(ADDR_COUNT)) u_dec (
    .take_cmd (take_cmd),
    .cmd_byte (in_byte),
    .cmd      (cmd)
  );

  disp_wr_seq #(.ADDR_COUNT(ADDR_COUNT), .SUB_W(SUB_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hw_sub    (hw_sub),
    .take_data (take_data),
    .data_byte (in_byte),
    .cmd       (cmd),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit    (wr_bit),
    .wr_val    (wr_val),
    .ptr       (ptr),
    .sub       (sub),
    .pos       (pos),
    .mode      (mode)
  );

  disp_seg_ram #(.ADDR_COUNT(ADDR_COUNT)) u_ram (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .wr_val  (wr_val),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/disp_ram_writer_chk.sv
module disp_ram_writer_chk
  import disp_pkg::*;
#(
  parameter int ADDR_COUNT = 40,
  parameter int SUB_W      = 3,
  localparam int ADDR_W    = $clog2(ADDR_COUNT)
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  in_valid,
  input logic                  in_cmd,
  input logic                  busy,
  input logic [ADDR_W-1:0]     ptr,
  input logic [SUB_W-1:0]      sub,
  input logic [CELL_IDX_W-1:0] pos,
  input mux_mode_e             mode
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [3:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   busy_run_q <= '0;
    else if (busy)     busy_run_q <= (busy_run_q == 4'hF) ? busy_run_q : busy_run_q + 4'd1;
    else               busy_run_q <= '0;
  end

  a_r2_busy_run_bounded: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_run_q <= 4'd8);

  a_r2_data_raises_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_cmd && !busy) |=> busy);

  a_r2_cmd_keeps_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_cmd && !busy) |=> !busy);

  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(ptr) < ADDR_COUNT);

  a_r8_pos_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pos <= last_pos(mode));

  a_r10_sub_steps_on_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> (sub == $past(sub)) || ((sub == $past(sub) + SUB_W'(1)) && (ptr == '0)));
endmodule

bind disp_ram_writer disp_ram_writer_chk #(.ADDR_COUNT(ADDR_COUNT), .SUB_W(SUB_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_cmd     (in_cmd),
  .busy       (busy),
  .ptr        (ptr),
  .sub        (sub),
  .pos        (pos),
  .mode       (mode)
);

// File: tb/test_disp_ram_writer.sv
module test_disp_ram_writer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NADDR = 40;

  logic       clk;
  logic       rst_n;
  logic [2:0] hw_sub;
  logic       in_valid;
  logic       in_cmd;
  logic [7:0] in_byte;
  logic       busy;
  logic [5:0] rd_addr;
  logic [3:0] rd_data;

  int checks;
  int failures;

  // bench-side expectation of the block
  logic [3:0] mref [NADDR];
  int m_ptr, m_pos, m_sub, m_mode, m_bank;

  disp_ram_writer i_disp_ram_writer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_sub   (hw_sub),
    .in_valid (in_valid),
    .in_cmd   (in_cmd),
    .in_byte  (in_byte),
    .busy     (busy),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    finish_run();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bits_per(input int mode);
    return mode + 1;
  endfunction

  function automatic int base_of(input int mode, input int bank);
    return (bank != 0 && mode < 2) ? 2 : 0;
  endfunction

  // R6 R7 R8 R9 R10 R11: expected storage of one data byte
  task automatic model_data(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      if (m_sub == int'(hw_sub))
        mref[m_ptr][base_of(m_mode, m_bank) + m_pos] = b[i];
      m_pos++;
      if (m_pos == bits_per(m_mode)) begin
        m_pos = 0;
        m_ptr++;
        if (m_ptr == NADDR) begin
          m_ptr = 0;
          m_sub = (m_sub + 1) % 8;
        end
      end
    end
  endtask

  // R3 R4 R5: expected effect of a command byte
  task automatic model_cmd(input logic [7:0] b);
    if (!b[7]) begin
      if (int'(b[5:0]) < NADDR) begin
        m_ptr = int'(b[5:0]);
        m_pos = 0;
      end
    end else begin
      case (b[6:5])
        2'b00: begin m_mode = int'(b[1:0]); m_pos = 0; end
        2'b01: m_sub = int'(b[2:0]);
        2'b10: m_bank = int'(b[0]);
        default: ;
      endcase
    end
  endtask

  task automatic send(input bit is_cmd, input logic [7:0] b, output int busy_cycles);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_cmd   = is_cmd;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    busy_cycles = 0;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
    if (is_cmd) model_cmd(b);
    else        model_data(b);
  endtask

  task automatic cmd(input logic [7:0] b);
    int bc;
    send(1'b1, b, bc);
    check(bc == 0, "R2 command raises no busy", bc, 0);
  endtask

  task automatic dat(input logic [7:0] b);
    int bc;
    send(1'b0, b, bc);
    check(bc == 8, "R2 data busy length", bc, 8);
  endtask

  task automatic cmp_ram(input string req);
    for (int a = 0; a < NADDR; a++) begin
      rd_addr = 6'(a);
      #1;
      check(rd_data == mref[a], req, int'(rd_data), int'(mref[a]));
    end
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; hw_sub = 3'd0; in_valid = 1'b0; in_cmd = 1'b0; in_byte = '0; rd_addr = '0;
    for (int a = 0; a < NADDR; a++) mref[a] = '0;
    m_ptr = 0; m_pos = 0; m_sub = 0; m_mode = 0; m_bank = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    cmp_ram("R1 cleared memory");
    rd_addr = 6'd50; #1;
    check(rd_data == 4'd0, "R12 out of range read", int'(rd_data), 0);

    // R1 R6: default static mode from pointer 0, device 0
    dat(8'hA5);
    cmp_ram("R6 static fill from reset");

    // R7: upper half in static mode
    cmd(8'hC1); cmd(8'h00); dat(8'h3C);
    cmp_ram("R7 static upper half");

    // R7 R6: two-way, both halves
    cmd(8'h81); cmd(8'h0A); dat(8'h96);
    cmd(8'hC0); dat(8'h5A);
    cmp_ram("R7 two-way halves");

    // R11: half selection ignored in four-way and three-way
    cmd(8'hC1); cmd(8'h83); cmd(8'h14); dat(8'hE7);
    cmd(8'h82); dat(8'h1B);
    cmp_ram("R11 half ignored in wide modes");

    // R8: three-way bytes straddling addresses, then mode change restarts position
    cmd(8'hC0); cmd(8'h82); cmd(8'h1E);
    dat(8'hF0); dat(8'h0F); dat(8'hAA);
    cmd(8'h82); dat(8'h55);
    cmp_ram("R8 three-way straddle");

    // R3: pointer load of 40 or more ignored
    cmd(8'h80); cmd(8'h20); cmd(8'h3F); dat(8'hC3);
    cmp_ram("R3 out-of-range load ignored");

    // R9 R10: start in a non-matching device, carry into the matching one mid-byte
    hw_sub = 3'd1;
    cmd(8'hA0); cmd(8'h24); dat(8'hFF);
    cmp_ram("R10 carry into matching device");

    // R9 R10: matching device runs off its end mid-byte; rest suppressed
    cmd(8'hA1); cmd(8'h26); dat(8'h00);
    cmp_ram("R9 suppressed after leaving device");

    // R10: three-way boundary inside a byte across devices
    hw_sub = 3'd3;
    cmd(8'h82); cmd(8'hA2); cmd(8'h26);
    dat(8'h6D); dat(8'hB2);
    cmp_ram("R10 three-way wrap mid-byte");

    // R5: no-operation command leaves state alone
    cmd(8'hE5); dat(8'h81);
    cmp_ram("R5 no-op command");

    // R2 R6 R9: constrained random stream
    begin
      int seed;
      int bc;
      seed = $urandom(32'h5EED_0042);
      for (int n = 0; n < 600; n++) begin
        int sel;
        sel = int'($urandom_range(0, 99));
        if (sel < 55) begin
          dat(8'($urandom));
        end else if (sel < 65) begin
          cmd({2'b00, 6'($urandom_range(0, 45))});
        end else if (sel < 73) begin
          cmd({6'b100000, 2'($urandom)});
        end else if (sel < 82) begin
          cmd({5'b10100, ($urandom_range(0, 3) != 0) ? hw_sub : 3'($urandom)});
        end else if (sel < 90) begin
          cmd({7'b1100000, 1'($urandom)});
        end else if (sel < 94) begin
          @(negedge clk);
          hw_sub = 3'($urandom);
        end else begin
          cmd({3'b111, 5'($urandom)});
        end
        if (n % 100 == 99) cmp_ram("R6 R9 random stream");
      end
      bc = 0;
    end
    cmp_ram("R6 random final");

    finish_run();
  end
endmodule